// File: doc/BRIEF.md
# Address-Triggered Banked RAM Mapper

This block sits behind a 4 KB cartridge window on an 8-bit CPU bus. It maps the window onto 8 KB of internal storage: three 2 KB RAM banks (numbered 0, 1 and 2) and one 2 KB ROM bank (number 3). Address bit 11 splits the window into a lower and an upper half. Each half is steered to a bank by a 5-bit configuration held inside the block.

The bus carries no write data toward the block. A data byte is taken from the low address bits of an access into a hold register. A later access commits it. That access must be exactly the fifth distinct bus access counted from the capture.

The same hold register supplies new configuration values. It is applied when the bus touches a fixed trigger address. The CPU drives one strobe per access and a flag telling whether the access is distinct. Read data, the live configuration and the ROM power status come back on the outputs.

Top module: `addr_banked_mapper`

## Requirements
- R1: After reset the configuration is 0 (bank map (2, ROM), writing disabled), `rom_pwr_on` is 1 and no write is pending.
- R2: Address bit 11 picks the half and bits 10:0 index into the bank. Configuration bits 4:2 give the (lower, upper) banks as 0=(2,ROM), 1=(0,ROM), 2=(2,0), 3=(0,2), 4=(2,ROM), 5=(1,ROM), 6=(2,1), 7=(1,2).
- R3: A window access (address bit 12 set) with bits 11:8 zero captures address bits 7:0 into the hold register. The capture also records the distinct-access count and marks a write pending. It happens only when writing is disabled or nothing is pending; otherwise that access is treated like any other window access.
- R4: An access to address 0x1FF8 clears the pending write and copies hold bits 4:0 into the configuration. Hold bits 7:5 are dropped. The configuration changes on no other access.
- R5: With writing enabled and a write pending, a window access that is the fifth distinct access after the capture stores the hold byte at its mapped location. The pending write then ends. Earlier accesses store nothing.
- R6: A pending write is dropped on any strobe that brings the distinct count more than five past the recorded count.
- R7: A commit whose target half maps the ROM bank stores nothing, but still ends the pending write. ROM byte at index i is (i[7:0] XOR i[10:8] XOR 0xA5).
- R8: `rd_data` is updated one clock after each window strobe. It holds the byte at the mapped location under the configuration that results from that access, and it includes a commit made by that same access.
- R9: Configuration bit 1 is write enable. Bit 0 is ROM power-off, and `rom_pwr_on` is its inverse.
- R10: A strobe with `bus_new` low does not advance the distinct count.
- R11: A strobe with address bit 12 clear captures nothing, applies nothing and commits nothing, and leaves `rd_data` unchanged. It still counts toward the distinct count and can expire a pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_strobe | input | 1 | One-cycle pulse per bus access |
| bus_addr | input | 13 | Access address; bit 12 marks the cartridge window |
| bus_new | input | 1 | Access is distinct from the previous one |
| rd_data | output | 8 | Byte read at the mapped location |
| cfg_state | output | 5 | Live configuration: bits 4:2 map, 1 write enable, 0 ROM power-off |
| rom_pwr_on | output | 1 | High while the ROM is powered |

## Verification
Several internal faults show only as a changed value, or as no change at all, at the exact commit access. These are a miscounted distinct-access gap, a hold register that reloads while a write is pending, and an expiry one access late. The fault appears on `rd_data` one clock after that strobe, or on a later read of the same location.

A wrong bank-map entry or a dropped configuration bit shows on `cfg_state` and on the next read of an affected half. A missing ROM write guard shows as a ROM read that no longer returns its computed pattern.

// File: rtl/abm_pkg.sv
package abm_pkg;
  localparam int ADDR_W  = 13;
  localparam int BANK_AW = 11;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 16;
  localparam int NUM_RAM = 3;

  typedef logic [1:0] bank_t;
  localparam bank_t ROM_BANK = 2'd3;

  typedef struct packed {
    logic [2:0] sel;
    logic       wr_en;
    logic       pwr_off;
  } cfg_t;

  typedef struct packed {
    bank_t lo;
    bank_t hi;
  } map_t;

  // Bank map for each selector value: (lower half, upper half)
  function automatic map_t bank_map(input logic [2:0] sel);
    map_t m;
    case (sel)
      3'd0:    m = '{lo: 2'd2, hi: ROM_BANK};
      3'd1:    m = '{lo: 2'd0, hi: ROM_BANK};
      3'd2:    m = '{lo: 2'd2, hi: 2'd0};
      3'd3:    m = '{lo: 2'd0, hi: 2'd2};
      3'd4:    m = '{lo: 2'd2, hi: ROM_BANK};
      3'd5:    m = '{lo: 2'd1, hi: ROM_BANK};
      3'd6:    m = '{lo: 2'd2, hi: 2'd1};
      default: m = '{lo: 2'd1, hi: 2'd2};
    endcase
    return m;
  endfunction

  // Fixed ROM pattern, computed rather than stored
  function automatic logic [DATA_W-1:0] rom_byte(input logic [BANK_AW-1:0] idx);
    return idx[7:0] ^ {5'b0, idx[10:8]} ^ 8'hA5;
  endfunction

  // Distinct accesses elapsed since a recorded count, modulo the counter width
  function automatic logic [CNT_W-1:0] age_of(input logic [CNT_W-1:0] now,
                                              input logic [CNT_W-1:0] rec);
    return now - rec;
  endfunction
endpackage

// File: rtl/abm_tracker.sv
module abm_tracker
  import abm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         fresh,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_now
);
  logic step;
  assign step    = strobe && fresh;
  assign cnt_now = cnt_q + W'(step);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_now;
  end

  // R10: the count only moves on distinct strobes
  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe && fresh) |-> $stable(cnt_q));
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && fresh) |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/abm_ctrl.sv
module abm_ctrl
  import abm_pkg::*;
#(
  parameter int                AW       = ADDR_W,
  parameter int                BW       = BANK_AW,
  parameter int                CW       = CNT_W,
  parameter int                PAGE_LSB = 8,
  parameter int                GAP      = 5,
  parameter logic [ADDR_W-1:0] HOTSPOT  = 13'h1FF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_now,
  output cfg_t          cfg_q,
  output logic          in_win,
  output bank_t         rd_bank,
  output logic          wr_fire,
  output bank_t         wr_bank,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [CW-1:0] GAP_V = CW'(GAP);

  logic [DATA_W-1:0] hold_q;
  logic [CW-1:0]     rec_q;
  logic              pend_q;

  logic [CW-1:0] age;
  logic          expire_evt, pend_live, page0;
  logic          load_evt, apply_evt, commit_evt, half;
  cfg_t          cfg_next;
  map_t          map_now, map_next;

  assign in_win     = strobe && addr[AW-1];
  assign age        = age_of(cnt_now, rec_q);
  assign expire_evt = strobe && pend_q && (age > GAP_V);
  assign pend_live  = pend_q && !expire_evt;
  assign page0      = (addr[AW-2:PAGE_LSB] == '0);
  assign half       = addr[BW];

  assign load_evt   = in_win && page0 && (!cfg_q.wr_en || !pend_live);
  assign apply_evt  = in_win && !load_evt && (addr == HOTSPOT);
  assign commit_evt = in_win && !load_evt && !apply_evt && cfg_q.wr_en
                      && pend_live && (age == GAP_V);

  assign map_now  = bank_map(cfg_q.sel);
  assign wr_bank  = half ? map_now.hi : map_now.lo;
  assign wr_fire  = commit_evt && (wr_bank != ROM_BANK);
  assign wr_data  = hold_q;

  assign cfg_next = apply_evt ? cfg_t'(hold_q[4:0]) : cfg_q;
  assign map_next = bank_map(cfg_next.sel);
  assign rd_bank  = half ? map_next.hi : map_next.lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      hold_q <= '0;
      rec_q  <= '0;
      pend_q <= 1'b0;
    end else if (load_evt) begin
      hold_q <= addr[DATA_W-1:0];
      rec_q  <= cnt_now;
      pend_q <= 1'b1;
    end else if (apply_evt) begin
      cfg_q  <= cfg_next;
      pend_q <= 1'b0;
    end else if (commit_evt || expire_evt) begin
      pend_q <= 1'b0;
    end
  end

  assert_evt_mutex_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, apply_evt, commit_evt}));
  assert_cfg_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(apply_evt) |-> $stable(cfg_q));
  assert_load_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (pend_q && rec_q == cnt_q));
  assert_commit_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !pend_q);
  assert_pend_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (age_of(cnt_q, rec_q) <= GAP_V));
  assert_no_win_act_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !addr[AW-1]) |=> ($stable(cfg_q) && $stable(hold_q)));
endmodule

// File: rtl/abm_store.sv
module abm_store
  import abm_pkg::*;
#(
  parameter int BW   = BANK_AW,
  parameter int NRAM = NUM_RAM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  bank_t             wr_bank,
  input  logic [BW-1:0]     idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  bank_t             rd_bank,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << BW;

  logic [DATA_W-1:0] bank_rd [NRAM];
  logic [DATA_W-1:0] rd_sel;
  logic              same_loc;

  for (genvar g = 0; g < NRAM; g++) begin : g_ram
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == bank_t'(g)) mem[idx] <= wr_data;
    end
    assign bank_rd[g] = mem[idx];
  end

  assign same_loc = wr_en && (wr_bank == rd_bank);

  always_comb begin
    if (rd_bank == ROM_BANK)          rd_sel = rom_byte(idx);
    else if (same_loc)                rd_sel = wr_data;
    else if (int'(rd_bank) < NRAM)    rd_sel = bank_rd[rd_bank];
    else                              rd_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end

  assert_no_rom_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_bank != ROM_BANK));
  assert_commit_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && same_loc) |=> (rd_data == $past(wr_data)));
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/addr_banked_mapper.sv
module addr_banked_mapper
  import abm_pkg::*;
#(
  parameter int                AW      = ADDR_W,
  parameter int                GAP     = 5,
  parameter logic [ADDR_W-1:0] HOTSPOT = 13'h1FF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_strobe,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_new,
  output logic [7:0]    rd_data,
  output logic [4:0]    cfg_state,
  output logic          rom_pwr_on
);
  logic [CNT_W-1:0]  cnt_q, cnt_now;
  cfg_t              cfg_q;
  logic              in_win, wr_fire;
  bank_t             rd_bank, wr_bank;
  logic [DATA_W-1:0] wr_data;

  abm_tracker #(.W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .strobe(bus_strobe), .fresh(bus_new),
    .cnt_q(cnt_q), .cnt_now(cnt_now)
  );

  abm_ctrl #(.AW(AW), .BW(BANK_AW), .CW(CNT_W), .PAGE_LSB(8), .GAP(GAP),
             .HOTSPOT(HOTSPOT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe(bus_strobe), .addr(bus_addr),
    .cnt_q(cnt_q), .cnt_now(cnt_now), .cfg_q(cfg_q), .in_win(in_win),
    .rd_bank(rd_bank), .wr_fire(wr_fire), .wr_bank(wr_bank), .wr_data(wr_data)
  );

  abm_store #(.BW(BANK_AW), .NRAM(NUM_RAM)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_bank(wr_bank),
    .idx(bus_addr[BANK_AW-1:0]), .wr_data(wr_data), .rd_en(in_win),
    .rd_bank(rd_bank), .rd_data(rd_data)
  );

  assign cfg_state  = cfg_q;
  assign rom_pwr_on = !cfg_q.pwr_off;

  assert_pwr_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_win) |-> $stable(rom_pwr_on));
endmodule

// File: tb/addr_banked_mapper_test.sv
`timescale 1ns/1ps
module addr_banked_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n, bus_strobe, bus_new;
  logic [12:0] bus_addr;
  wire  [7:0]  rd_data;
  wire  [4:0]  cfg_state;
  wire         rom_pwr_on;

  always #2.5 clk = ~clk;

  addr_banked_mapper uut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .bus_new(bus_new), .rd_data(rd_data), .cfg_state(cfg_state),
    .rom_pwr_on(rom_pwr_on)
  );

  int checks = 0, errors = 0, out_k = 0;
  bit done = 1'b0;

  bit [15:0]   m_cnt, m_rec;
  bit          m_pend;
  bit [7:0]    m_hold, last_rd;
  bit [4:0]    m_cfg;
  bit [12:0]   prev_a;
  logic [7:0]  m_ram [3][2048];
  bit          m_known [3][2048];

  function automatic bit [1:0] lo_of(input bit [2:0] s);
    if (!s[0]) return 2'd2;
    return s[2] ? 2'd1 : 2'd0;
  endfunction
  function automatic bit [1:0] hi_of(input bit [2:0] s);
    if (!s[1]) return 2'd3;
    if (s[0]) return 2'd2;
    return s[2] ? 2'd1 : 2'd0;
  endfunction
  function automatic bit [7:0] rom_val(input int i);
    return 8'((i & 255) ^ ((i >> 8) & 7) ^ 165);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One access: drive at a falling edge, sample at the next falling edge
  task automatic acc(input bit [12:0] a, input bit repeat_same = 1'b0);
    bit nf;
    bit [1:0] b;
    int idx;
    nf = repeat_same ? 1'b0 : (a != prev_a);
    bus_addr = a; bus_new = nf; bus_strobe = 1'b1;
    @(negedge clk);
    bus_strobe = 1'b0;
    if (nf) m_cnt = m_cnt + 16'd1;
    if (m_pend && 16'(m_cnt - m_rec) > 16'd5) m_pend = 1'b0;
    idx = int'(a[10:0]);
    if (a[12]) begin
      if (a[11:8] == 4'd0 && (!m_cfg[1] || !m_pend)) begin
        m_hold = a[7:0]; m_rec = m_cnt; m_pend = 1'b1;
      end else if (a == 13'h1FF8) begin
        m_pend = 1'b0; m_cfg = m_hold[4:0];
      end else if (m_cfg[1] && m_pend && 16'(m_cnt - m_rec) == 16'd5) begin
        b = a[11] ? hi_of(m_cfg[4:2]) : lo_of(m_cfg[4:2]);
        if (b != 2'd3) begin
          m_ram[b][idx] = m_hold; m_known[b][idx] = 1'b1;
        end
        m_pend = 1'b0;
      end
      b = a[11] ? hi_of(m_cfg[4:2]) : lo_of(m_cfg[4:2]);
      if (b == 2'd3) chk("R8 rom read", int'(rd_data), int'(rom_val(idx)));
      else if (m_known[b][idx]) chk("R8 ram read", int'(rd_data), int'(m_ram[b][idx]));
      last_rd = rd_data;
    end else begin
      chk("R11 read unchanged", int'(rd_data), int'(last_rd));
    end
    chk("R4 config", int'(cfg_state), int'(m_cfg));
    chk("R9 rom power", int'(rom_pwr_on), int'(!m_cfg[0]));
    prev_a = a;
  endtask

  task automatic outside(input int n);
    for (int i = 0; i < n; i++) begin
      acc(13'h0400 + 13'(out_k % 512));
      out_k++;
    end
  endtask

  task automatic set_cfg(input bit [7:0] v);
    acc(13'h1000 | 13'(v));
    acc(13'h1FF8);
  endtask

  task automatic put(input bit [12:0] a, input bit [7:0] v);
    acc(13'h1000 | 13'(v));
    outside(4);
    acc(a);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [12:0] a;
    int r;
    void'($urandom(32'd1789));
    rst_n = 1'b0; bus_strobe = 1'b0; bus_new = 1'b0; bus_addr = '0;
    m_cnt = 0; m_rec = 0; m_pend = 0; m_hold = 0; m_cfg = 0; prev_a = 0; last_rd = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg after reset", int'(cfg_state), 0);
    chk("R1 rom powered after reset", int'(rom_pwr_on), 1);

    // R4 with ignored upper bits, write enable on, map (0,2)
    set_cfg(8'hEE);
    chk("R4 hold bits 7:5 dropped", int'(cfg_state), 5'h0E);
    // R5 commit on fifth distinct access
    put(13'h1123, 8'h5A);
    chk("R5 commit value", int'(rd_data), 8'h5A);
    acc(13'h1077); outside(3); acc(13'h1123);
    chk("R5 no commit at fourth", int'(rd_data), 8'h5A);
    acc(13'h1124);
    chk("R5 commit at fifth", int'(rd_data), 8'h77);
    // R6 expiry
    acc(13'h1033); outside(5); acc(13'h1123);
    chk("R6 expired no write", int'(rd_data), 8'h5A);
    acc(13'h1124);
    chk("R6 other location intact", int'(rd_data), 8'h77);
    // R10 repeated access does not count
    acc(13'h1044); outside(4);
    acc(prev_a, 1'b1); acc(prev_a, 1'b1);
    acc(13'h1200);
    chk("R10 commit after repeats", int'(rd_data), 8'h44);
    // R7 ROM guard, R3 capture blocked while pending
    set_cfg(8'h02);
    chk("R4 cfg map 0", int'(cfg_state), 5'h02);
    put(13'h1900, 8'h99);
    chk("R7 rom unchanged", int'(rd_data), int'(rom_val(12'h100)));
    put(13'h1010, 8'hAB);
    chk("R3 capture blocked, commit wins", int'(rd_data), 8'hAB);
    // R2 mapping and R9 power bit
    set_cfg(8'h1D);
    chk("R9 rom power off", int'(rom_pwr_on), 0);
    acc(13'h1810);
    chk("R2 upper half bank 2", int'(rd_data), 8'hAB);
    set_cfg(8'h0C);
    acc(13'h1123);
    chk("R2 lower half bank 0", int'(rd_data), 8'h5A);
    acc(13'h1810);
    chk("R2 upper half bank 2 again", int'(rd_data), 8'hAB);
    // R11 outside window
    acc(13'h0055); acc(13'h0FF8);
    chk("R11 cfg untouched", int'(cfg_state), 5'h0C);
    acc(13'h1FF8);
    chk("R11 hold untouched", int'(cfg_state), 5'h0C);
    // R3 recapture while writing disabled
    acc(13'h1010); acc(13'h1004); acc(13'h1FF8);
    chk("R3 latest capture applied", int'(cfg_state), 5'h04);
    acc(13'h1F00);
    chk("R7 rom pattern", int'(rd_data), int'(rom_val(12'h700)));

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      r = int'($urandom % 16);
      if (r < 3)       a = 13'h1000 | 13'($urandom % 256);
      else if (r == 3) a = 13'h1FF8;
      else if (r < 6)  a = {1'b0, 12'($urandom)};
      else if (r == 6) a = prev_a;
      else             a = {1'b1, 1'($urandom), 3'b101, 5'b0, 3'($urandom)};
      acc(a, r == 6);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule